// File: doc/BRIEF.md
# Hardware Descriptor Queue Manager

This block keeps a set of hardware packet queues whose entries are descriptor words. No queue has storage of its own. All of them share one pool of slots, and the slots form singly linked lists through a linking RAM. Slots that no queue holds sit on a free list in the same RAM. Each pushed word keeps its full value. The low four bits are a size hint and the upper bits are a 16-byte-aligned descriptor pointer.

Software reaches every queue through a simple word-addressed register slave. The address is `{queue, view, reg}`. Writing register 3 of the push view enqueues a word. Reading register 3 of the pop view dequeues the head entry. The peek view returns the same head and the same counts without removing anything. A fourth view per queue holds a threshold byte. Its bit 7 sets the compare direction and bits 6:0 hold the level. The same view also exposes a sticky push-error bit, shared by all queues. Every queue drives one threshold flag output.

Top module: `hw_queue_mgr`

## Requirements
- R1: Within each queue, entries leave in the order they entered (pushes at the tail, pops from the head), independent of traffic on other queues.
- R2: A pop returns the full 32-bit word that was pushed, with its size hint in bits 3:0 preserved.
- R3: Register 0 of any of views 0, 1 or 2 returns the queue's entry count. A successful push adds one and a successful pop subtracts one.
- R4: Register 1 returns the queue's byte count. A push adds the value last written to register 2 of that queue's push view. A pop subtracts the size stored with the removed entry.
- R5: A pop read of an empty queue returns 0 and leaves counts and contents unchanged.
- R6: A read of register 3 in the peek view (view 2) returns the head word and removes nothing.
- R7: Threshold byte is register 0 of view 3. With bit 7 set, the queue's flag is high when count >= bits 6:0. With bit 7 clear, the flag is high when count < bits 6:0.
- R8: A push when no free slot remains is dropped and sets the sticky error bit (bit 0 of register 1, view 3). Writing 1 to that bit clears it.
- R9: Slots are shared. Queue counts plus free slots always equal the slot total, and a popped slot can be reused by any queue.
- R10: After reset, all counts, flags, the error bit, `bus_rvalid` and `bus_rdata` are 0.
- R11: Read data appears on `bus_rdata` with `bus_rvalid` high exactly one cycle after the read request.
- R12: Writes to the count registers (registers 0 and 1) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | QW+4 | {queue, view[1:0], reg[1:0]} |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| bus_rvalid | output | 1 | Read data valid |
| thresh_flag | output | NQ | Per-queue threshold status |

## Verification
The bench empties the shared slot pool completely, because a design that miscounted free slots would either accept the overflowing push (and corrupt another list) or refuse a push after a pop returned a slot. It pops empty queues, where a design that still advanced the head would return stale words and go negative on its counts. It interleaves queues to expose broken next links, which show up as out-of-order or lost entries. It also flips the threshold direction at the exact boundary count, where an off-by-one compare sets the flag one entry early or late.

// File: rtl/hw_queue_mgr.sv
module hw_queue_mgr #(
  parameter int NQ    = 4,
  parameter int NDESC = 16,
  parameter int DW    = 32,
  parameter int PSW   = 16,
  parameter int BCW   = 24,
  localparam int QW   = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int AW   = QW + 4,
  localparam int IW   = (NDESC > 1) ? $clog2(NDESC) : 1,
  localparam int CW   = $clog2(NDESC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_rvalid,
  output logic [NQ-1:0] thresh_flag
);

  logic [DW-1:0]  slot_word [NDESC];
  logic [PSW-1:0] slot_size [NDESC];
  logic [IW-1:0]  nxt [NDESC];

  logic [NQ-1:0][IW-1:0]  q_head, q_tail;
  logic [NQ-1:0][CW-1:0]  q_cnt;
  logic [NQ-1:0][BCW-1:0] q_bytes;
  logic [NQ-1:0][PSW-1:0] q_pend;
  logic [NQ-1:0][6:0]     q_thr;
  logic [NQ-1:0]          q_dir;
  logic [IW-1:0]          free_head;
  logic [CW-1:0]          free_cnt;
  logic                   push_err;

  logic [QW-1:0] qsel;
  logic [1:0]    view, rsel;
  logic          q_ok, has, do_push, push_req, do_pop;
  logic [IW-1:0] hd;
  logic [DW-1:0] rd_val;

  assign qsel = bus_addr[AW-1:4];
  assign view = bus_addr[3:2];
  assign rsel = bus_addr[1:0];
  assign q_ok = 32'(qsel) < NQ;
  assign has  = q_ok && (q_cnt[qsel] != '0);
  assign hd   = q_head[qsel];

  assign push_req = bus_sel && bus_wr && q_ok && view == 2'd0 && rsel == 2'd3;
  assign do_push  = push_req && (free_cnt != '0);
  assign do_pop   = bus_sel && !bus_wr && has && view == 2'd1 && rsel == 2'd3;

  always_comb begin
    rd_val = '0;
    if (q_ok) begin
      if (view == 2'd3) begin
        if (rsel == 2'd0) rd_val = DW'({q_dir[qsel], q_thr[qsel]});
        else if (rsel == 2'd1) rd_val = DW'(push_err);
      end else begin
        case (rsel)
          2'd0: rd_val = DW'(q_cnt[qsel]);
          2'd1: rd_val = DW'(q_bytes[qsel]);
          2'd2: rd_val = (view == 2'd0) ? DW'(q_pend[qsel])
                                        : (has ? DW'(slot_size[hd]) : '0);
          default: rd_val = (view != 2'd0 && has) ? slot_word[hd] : '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) begin
      slot_word[free_head] <= bus_wdata;
      slot_size[free_head] <= q_pend[qsel];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NDESC; i++) nxt[i] <= IW'(i + 1);
      q_head     <= '0;
      q_tail     <= '0;
      q_cnt      <= '0;
      q_bytes    <= '0;
      q_pend     <= '0;
      q_thr      <= '0;
      q_dir      <= '0;
      free_head  <= '0;
      free_cnt   <= CW'(NDESC);
      push_err   <= 1'b0;
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_sel && !bus_wr;
      if (bus_sel && !bus_wr) bus_rdata <= rd_val;

      if (bus_sel && bus_wr && q_ok) begin
        if (view == 2'd0 && rsel == 2'd2) q_pend[qsel] <= bus_wdata[PSW-1:0];
        if (view == 2'd3 && rsel == 2'd0) begin
          q_thr[qsel] <= bus_wdata[6:0];
          q_dir[qsel] <= bus_wdata[7];
        end
        if (view == 2'd3 && rsel == 2'd1 && bus_wdata[0]) push_err <= 1'b0;
      end

      if (push_req && !do_push) push_err <= 1'b1;

      if (do_push) begin
        free_head <= nxt[free_head];
        free_cnt  <= free_cnt - 1'b1;
        if (q_cnt[qsel] == '0) q_head[qsel] <= free_head;
        else nxt[q_tail[qsel]] <= free_head;
        q_tail[qsel]  <= free_head;
        q_cnt[qsel]   <= q_cnt[qsel] + 1'b1;
        q_bytes[qsel] <= q_bytes[qsel] + BCW'(q_pend[qsel]);
      end

      if (do_pop) begin
        q_head[qsel]  <= nxt[hd];
        nxt[hd]       <= free_head;
        free_head     <= hd;
        free_cnt      <= free_cnt + 1'b1;
        q_cnt[qsel]   <= q_cnt[qsel] - 1'b1;
        q_bytes[qsel] <= q_bytes[qsel] - BCW'(slot_size[hd]);
      end
    end
  end

  for (genvar g = 0; g < NQ; g++) begin : g_flag
    assign thresh_flag[g] = q_dir[g] ? (32'(q_cnt[g]) >= 32'(q_thr[g]))
                                     : (32'(q_cnt[g]) <  32'(q_thr[g]));
  end

endmodule

// File: rtl/hw_queue_mgr_chk.sv
module hw_queue_mgr_chk #(
  parameter int NQ    = 4,
  parameter int NDESC = 16,
  parameter int DW    = 32,
  localparam int QW   = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int AW   = QW + 4,
  localparam int CW   = $clog2(NDESC + 1)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_sel,
  input logic                  bus_wr,
  input logic [AW-1:0]         bus_addr,
  input logic [DW-1:0]         bus_rdata,
  input logic                  bus_rvalid,
  input logic [NQ-1:0]         thresh_flag,
  input logic [NQ-1:0][CW-1:0] q_cnt,
  input logic [CW-1:0]         free_cnt,
  input logic                  push_err,
  input logic [NQ-1:0][6:0]    q_thr,
  input logic [NQ-1:0]         q_dir
);

  logic [QW-1:0] ck_q;
  logic          ck_rd, ck_empty_pop, ck_push;
  int            total;

  assign ck_q  = bus_addr[AW-1:4];
  assign ck_rd = bus_sel && !bus_wr;
  assign ck_empty_pop = ck_rd && bus_addr[3:0] == 4'b0111 &&
                        32'(ck_q) < NQ && q_cnt[ck_q] == '0;
  assign ck_push = bus_sel && bus_wr && bus_addr[3:0] == 4'b0011;

  always_comb begin
    total = 32'(free_cnt);
    for (int i = 0; i < NQ; i++) total += 32'(q_cnt[i]);
  end

  assert_read_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ck_rd |=> bus_rvalid);
  assert_no_spurious_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ck_rd |=> !bus_rvalid);
  assert_empty_pop_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ck_empty_pop |=> bus_rdata == '0);
  assert_slot_conservation_R9: assert property (@(posedge clk) disable iff (!rst_n)
    total == NDESC);
  assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(push_err) |-> $past(ck_push && free_cnt == '0));
  assert_flag_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(q_cnt) && $stable(q_thr) && $stable(q_dir)) |-> $stable(thresh_flag));

endmodule

bind hw_queue_mgr hw_queue_mgr_chk #(.NQ(NQ), .NDESC(NDESC), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
  .thresh_flag(thresh_flag), .q_cnt(q_cnt), .free_cnt(free_cnt),
  .push_err(push_err), .q_thr(q_thr), .q_dir(q_dir)
);

// File: tb/sim_hw_queue_mgr.sv
module sim_hw_queue_mgr;
  localparam int CLK_PERIOD = 10;
  localparam int NQ = 4;
  localparam int NDESC = 16;

  logic        clk = 0, rst_n = 0, sel = 0, wr = 0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        rvalid;
  logic [3:0]  flag;
  int checks = 0, errors = 0;

  hw_queue_mgr u0 (.clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
    .bus_rvalid(rvalid), .thresh_flag(flag));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {logic w; logic [5:0] a; logic [31:0] d; logic [31:0] e;} vec_t;
  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 6'b00_00_10, 32'd100,        32'd0},        // size for next push (R4)
    '{1'b1, 6'b00_00_11, 32'h1000_0013, 32'd0},        // push (R2)
    '{1'b1, 6'b00_00_10, 32'd60,         32'd0},
    '{1'b1, 6'b00_00_11, 32'h2000_0025, 32'd0},
    '{1'b0, 6'b00_00_00, 32'd0,          32'd2},        // count R3
    '{1'b0, 6'b00_00_01, 32'd0,          32'd160},      // bytes R4
    '{1'b0, 6'b00_10_11, 32'd0,          32'h1000_0013},// peek R6
    '{1'b0, 6'b00_10_00, 32'd0,          32'd2},        // peek keeps count R6
    '{1'b0, 6'b00_01_11, 32'd0,          32'h1000_0013},// pop R2
    '{1'b0, 6'b00_01_00, 32'd0,          32'd1},        // count R3
    '{1'b0, 6'b00_01_01, 32'd0,          32'd60},       // bytes R4
    '{1'b0, 6'b00_01_11, 32'd0,          32'h2000_0025},// pop R1
    '{1'b0, 6'b00_01_11, 32'd0,          32'd0},        // empty pop R5
    '{1'b0, 6'b00_00_00, 32'd0,          32'd0}         // count unchanged R5
  };

  function automatic logic [5:0] ad(int q, int v, int r);
    return 6'(q * 16 + v * 4 + r);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bw(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; wr = 0;
  endtask

  task automatic br(input logic [5:0] a, output logic [31:0] v);
    @(negedge clk); sel = 1; wr = 0; addr = a;
    @(negedge clk); sel = 0; v = rdata;
  endtask

  task automatic do_reset();
    rst_n = 0; sel = 0; wr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL R11 watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    do_reset();
    @(negedge clk);
    chk("R10 rvalid", 32'(rvalid), 0);
    chk("R10 rdata", rdata, 0);
    chk("R10 flags", 32'(flag), 0);
    br(ad(0, 3, 1), v); chk("R10 err", v, 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].w) bw(VEC[i].a, VEC[i].d);
      else begin
        br(VEC[i].a, v);
        chk($sformatf("vector %0d", i), v, VEC[i].e);
      end
    end

    // R11: valid for one cycle after a read
    br(ad(1, 0, 0), v); chk("R11 rvalid high", 32'(rvalid), 1);
    @(negedge clk); chk("R11 rvalid low", 32'(rvalid), 0);

    // R1: interleaved queues keep their own order
    bw(ad(1, 0, 3), 32'hA0); bw(ad(2, 0, 3), 32'hB0);
    bw(ad(1, 0, 3), 32'hA1); bw(ad(2, 0, 3), 32'hB1); bw(ad(1, 0, 3), 32'hA2);
    br(ad(1, 1, 3), v); chk("R1 q1 first", v, 32'hA0);
    br(ad(2, 1, 3), v); chk("R1 q2 first", v, 32'hB0);
    bw(ad(2, 0, 3), 32'hB2);
    br(ad(1, 1, 3), v); chk("R1 q1 second", v, 32'hA1);
    br(ad(1, 1, 3), v); chk("R1 q1 third", v, 32'hA2);
    br(ad(2, 1, 3), v); chk("R1 q2 second", v, 32'hB1);
    br(ad(2, 1, 3), v); chk("R1 q2 third", v, 32'hB2);

    // R12: count writes ignored
    bw(ad(1, 0, 3), 32'hC0);
    bw(ad(1, 0, 0), 32'd9); bw(ad(1, 0, 1), 32'd77);
    br(ad(1, 0, 0), v); chk("R12 count", v, 1);
    br(ad(1, 0, 1), v); chk("R12 bytes", v, 0);
    br(ad(1, 1, 3), v); chk("R12 content", v, 32'hC0);

    // R7: threshold direction at the boundary
    bw(ad(3, 3, 0), 32'h82);
    bw(ad(3, 0, 3), 32'h30); chk("R7 ge below", 32'(flag[3]), 0);
    bw(ad(3, 0, 3), 32'h31); chk("R7 ge at level", 32'(flag[3]), 1);
    bw(ad(3, 3, 0), 32'h02); chk("R7 lt at level", 32'(flag[3]), 0);
    br(ad(3, 3, 0), v); chk("R7 cfg readback", v, 32'h02);
    br(ad(3, 1, 3), v); chk("R7 lt below", 32'(flag[3]), 1);

    // R8 / R9: exhaust shared slots
    do_reset();
    for (int i = 0; i < NDESC; i++) bw(ad(2, 0, 3), 32'(i * 16 + 16));
    br(ad(2, 0, 0), v); chk("R8 full count", v, NDESC);
    bw(ad(0, 0, 3), 32'hDEAD_0000);
    br(ad(0, 0, 0), v); chk("R8 dropped count", v, 0);
    br(ad(0, 3, 1), v); chk("R8 err set", v, 1);
    br(ad(1, 3, 1), v); chk("R8 err sticky", v, 1);
    bw(ad(0, 3, 1), 32'd1);
    br(ad(0, 3, 1), v); chk("R8 err cleared", v, 0);
    br(ad(2, 1, 3), v); chk("R9 pop first", v, 32'h10);
    bw(ad(0, 0, 3), 32'hBEEF_0000);
    br(ad(0, 0, 0), v); chk("R9 reuse count", v, 1);
    br(ad(0, 3, 1), v); chk("R9 no err", v, 0);
    br(ad(0, 1, 3), v); chk("R9 reused word", v, 32'hBEEF_0000);
    for (int i = 1; i < NDESC; i++) begin
      br(ad(2, 1, 3), v); chk("R1 drain order", v, 32'(i * 16 + 16));
    end
    br(ad(2, 1, 3), v); chk("R5 drained empty", v, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule